// File: doc/BRIEF.md
# Phase-Aligned Five-Bank Clock Divider

This block turns one pre-divided clock into five output banks, each with its own divide ratio. It is fully synchronous. The pre-divided clock is modelled as a phase that changes level on every system clock cycle. Every bank output is a registered logic level, with a true output and a complement output. Four banks each drive one pair. The fifth bank drives three pairs that always carry the same waveform.

Each bank has a two-bit code that selects one of four modes: disabled, divide by two, divide by eight, or pass-through. All dividers share one down-counting phase counter. One full count of that counter is a 16-cycle frame. At the last cycle of each frame every divider stage is low. This all-low point is where code changes take effect, where a stop takes effect, and where a restart begins.

A shared active-low synchronization input stops and restarts all banks. It first passes through a two-flop synchronizer. It must then stay low for at least eight synchronized cycles. When that happens, the banks finish their current frame and hold low. When the input returns high, all enabled banks start again and rise in the same cycle. Software reprograms the bank codes and then pulses this input so that all banks come back phase-aligned.

The sequencer has four states:
- `ST_RUN`: normal running.
- `ST_ARM`: the input is low and the low time is being measured.
- `ST_DRAIN`: the pulse is qualified and the block waits for the frame end.
- `ST_HALT`: all outputs are held low and the counter is preset.

The transitions are:
- RUN to ARM when the synchronized input is low.
- ARM back to RUN when the input rises before eight low samples.
- ARM to DRAIN on the eighth low sample.
- DRAIN to HALT at the all-low frame end.
- HALT to RUN when the input is high.

Top module: `clkbank_top`

## Requirements
- R1: There are five banks. Banks 0 to 3 each drive one pair on `clk_out_p[b]`/`clk_out_n[b]`. Bank 4 drives all three `fan_out` pairs, and these three pairs carry an identical waveform.
- R2: Bank b is programmed by `bank_cfg[2b+1:2b]`, where bit 2b+1 is the select bit and bit 2b is the enable bit. The codes are:
  - 00: disabled.
  - 01: divide by 2. The output changes level every 2 cycles.
  - 10: divide by 8. The output changes level every 8 cycles.
  - 11: pass-through. The output changes level every cycle.
  Every enabled waveform starts with its high phase at the beginning of a frame.
- R3: A disabled bank holds its true output low and its complement output high. For every bank and at all times, the complement output is the inverse of the true output.
- R4: If the synchronized input is low for 8 or more consecutive cycles:
  - every bank completes its current 16-cycle frame without truncation;
  - every true output then holds low for as long as the block is halted.
- R5: A low on the synchronized input that lasts 7 cycles or less is ignored, and every output continues its waveform unchanged.
- R6: After a halt, when the input returns high, all enabled banks rise in the same cycle. They then follow their R2 patterns aligned to that cycle.
- R7: If a bank code changes while the block is running, the new code takes effect at the next frame boundary, with no runt pulse. The current frame completes with the old code.
- R8: While reset is high:
  - all true outputs are low and all complement outputs are high;
  - the phase counter is cleared;
  - the synchronizer is preset high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_n | input | 1 | Asynchronous active-low stop/realign request |
| bank_cfg | input | 10 | Two-bit mode code per bank; bank b at bits [2b+1:2b] |
| clk_out_p | output | 4 | True outputs of banks 0 to 3 |
| clk_out_n | output | 4 | Complement outputs of banks 0 to 3 |
| fan_out_p | output | 3 | True outputs of the three bank-4 pairs |
| fan_out_n | output | 3 | Complement outputs of the three bank-4 pairs |

## Verification
A corrupted phase counter shows up within one frame, as an edge at the wrong offset in some bank's pattern. A bad count in the low-time filter shows up within a few cycles of the pulse: a 7-cycle pulse would stop the banks, or an 8-cycle pulse would fail to stop them. A wrong transition in the sequencer shows up at the frame end. It appears as a truncated high phase, or as outputs still toggling during a halt. A code register that loads at the wrong time shows up at the next frame boundary, as a pattern that changes mid-frame.

// File: rtl/clkbank_pkg.sv
package clkbank_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_ARM   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_HALT  = 2'd3
    } seq_state_t;

    // {select, enable}
    typedef enum logic [1:0] {
        CFG_OFF  = 2'b00,
        CFG_MID  = 2'b01,
        CFG_SLOW = 2'b10,
        CFG_PASS = 2'b11
    } bank_cfg_t;

endpackage

// File: rtl/clkbank_seq.sv
module clkbank_seq
    import clkbank_pkg::*;
#(
    parameter int MIN_LOW = 8,
    parameter int PHASE_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sync_n,
    output seq_state_t         state,
    output logic [PHASE_W-1:0] phase,
    output logic               gate,
    output logic               frame_end,
    output logic               sync_lvl
);
    localparam int LOW_W = $clog2(MIN_LOW + 1);

    logic             sync_m, sync_q;
    logic [LOW_W-1:0] low_cnt;
    seq_state_t       state_q, state_d;
    logic [PHASE_W-1:0] phase_q;

    // Two-flop synchronizer, preset to the idle (high) level.
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_m <= 1'b1;
            sync_q <= 1'b1;
        end else begin
            sync_m <= sync_n;
            sync_q <= sync_m;
        end
    end

    assign frame_end = (phase_q == '0);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (!sync_q) state_d = ST_ARM;
            end
            ST_ARM: begin
                if (sync_q)
                    state_d = ST_RUN;
                else if (low_cnt == LOW_W'(MIN_LOW - 1))
                    state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (frame_end) state_d = ST_HALT;
            end
            ST_HALT: begin
                if (sync_q) state_d = ST_RUN;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RUN;
        else     state_q <= state_d;
    end

    // Phase counter and low-time filter.
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            low_cnt <= '0;
        end else begin
            if (state_q == ST_HALT) phase_q <= '1;
            else                    phase_q <= phase_q - 1'b1;

            if (state_q == ST_RUN && !sync_q)
                low_cnt <= LOW_W'(1);
            else if (state_q == ST_ARM && !sync_q)
                low_cnt <= low_cnt + 1'b1;
            else
                low_cnt <= '0;
        end
    end

    assign state    = state_q;
    assign phase    = phase_q;
    assign gate     = (state_q != ST_HALT);
    assign sync_lvl = sync_q;

endmodule

// File: rtl/clkbank_lane.sv
module clkbank_lane
    import clkbank_pkg::*;
#(
    parameter int PHASE_W  = 4,
    parameter int MID_IDX  = 1,
    parameter int SLOW_IDX = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               gate,
    input  logic               frame_end,
    input  logic [PHASE_W-1:0] phase,
    input  logic [1:0]         cfg,
    output logic               out_p,
    output logic               out_n
);
    bank_cfg_t active_q;
    logic      tap;

    always_comb begin
        unique case (active_q)
            CFG_OFF:  tap = 1'b0;
            CFG_MID:  tap = phase[MID_IDX];
            CFG_SLOW: tap = phase[SLOW_IDX];
            CFG_PASS: tap = phase[0];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= CFG_OFF;
            out_p    <= 1'b0;
            out_n    <= 1'b1;
        end else begin
            if (frame_end || !gate) active_q <= bank_cfg_t'(cfg);
            out_p <= gate & tap;
            out_n <= ~(gate & tap);
        end
    end

endmodule

// File: rtl/clkbank_top.sv
module clkbank_top
    import clkbank_pkg::*;
#(
    parameter int NUM_SINGLE = 4,
    parameter int FAN_PAIRS  = 3,
    parameter int MIN_LOW    = 8,
    parameter int MID_DIV    = 2,
    parameter int SLOW_DIV   = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      sync_n,
    input  logic [2*(NUM_SINGLE+1)-1:0] bank_cfg,
    output logic [NUM_SINGLE-1:0]     clk_out_p,
    output logic [NUM_SINGLE-1:0]     clk_out_n,
    output logic [FAN_PAIRS-1:0]      fan_out_p,
    output logic [FAN_PAIRS-1:0]      fan_out_n
);
    localparam int NUM_BANKS = NUM_SINGLE + 1;
    localparam int PHASE_W   = $clog2(2 * SLOW_DIV);
    localparam int MID_IDX   = $clog2(MID_DIV);
    localparam int SLOW_IDX  = $clog2(SLOW_DIV);

    seq_state_t         seq_state;
    logic [PHASE_W-1:0] phase;
    logic               gate, frame_end, sync_lvl;
    logic [NUM_BANKS-1:0] lane_p, lane_n;

    clkbank_seq #(.MIN_LOW(MIN_LOW), .PHASE_W(PHASE_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .sync_n    (sync_n),
        .state     (seq_state),
        .phase     (phase),
        .gate      (gate),
        .frame_end (frame_end),
        .sync_lvl  (sync_lvl)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_lane
        clkbank_lane #(
            .PHASE_W (PHASE_W),
            .MID_IDX (MID_IDX),
            .SLOW_IDX(SLOW_IDX)
        ) u_lane (
            .clk       (clk),
            .rst       (rst),
            .gate      (gate),
            .frame_end (frame_end),
            .phase     (phase),
            .cfg       (bank_cfg[2*b +: 2]),
            .out_p     (lane_p[b]),
            .out_n     (lane_n[b])
        );
    end

    assign clk_out_p = lane_p[NUM_SINGLE-1:0];
    assign clk_out_n = lane_n[NUM_SINGLE-1:0];

    for (genvar f = 0; f < FAN_PAIRS; f++) begin : g_fan
        assign fan_out_p[f] = lane_p[NUM_SINGLE];
        assign fan_out_n[f] = lane_n[NUM_SINGLE];
    end

endmodule

// File: rtl/clkbank_chk.sv
module clkbank_chk
    import clkbank_pkg::*;
#(
    parameter int NUM_SINGLE = 4,
    parameter int FAN_PAIRS  = 3,
    parameter int PHASE_W    = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sync_lvl,
    input  seq_state_t            seq_state,
    input  logic [PHASE_W-1:0]    phase,
    input  logic                  frame_end,
    input  logic [NUM_SINGLE-1:0] clk_out_p,
    input  logic [NUM_SINGLE-1:0] clk_out_n,
    input  logic [FAN_PAIRS-1:0]  fan_out_p,
    input  logic [FAN_PAIRS-1:0]  fan_out_n
);
    AST_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
        (clk_out_n == ~clk_out_p) && (fan_out_n == ~fan_out_p)); // R3

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (seq_state == ST_HALT) |=> (clk_out_p == '0) && (fan_out_p == '0)); // R4

    AST_DRAIN_END: assert property (@(posedge clk) disable iff (rst)
        (seq_state == ST_DRAIN && frame_end) |=> (seq_state == ST_HALT)); // R4

    AST_SHORT_LOW: assert property (@(posedge clk) disable iff (rst)
        (seq_state == ST_ARM && sync_lvl) |=> (seq_state == ST_RUN)); // R5

    AST_RESTART_TOP: assert property (@(posedge clk) disable iff (rst)
        (seq_state == ST_HALT && sync_lvl) |=> (seq_state == ST_RUN) && (phase == '1)); // R6

endmodule

bind clkbank_top clkbank_chk #(
    .NUM_SINGLE(NUM_SINGLE),
    .FAN_PAIRS (FAN_PAIRS),
    .PHASE_W   (PHASE_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sync_lvl  (sync_lvl),
    .seq_state (seq_state),
    .phase     (phase),
    .frame_end (frame_end),
    .clk_out_p (clk_out_p),
    .clk_out_n (clk_out_n),
    .fan_out_p (fan_out_p),
    .fan_out_n (fan_out_n)
);

// File: tb/tb_clkbank_top.sv
module tb_clkbank_top;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sync_n = 1'b1;
    logic [9:0] bank_cfg = '0;
    logic [3:0] clk_out_p, clk_out_n;
    logic [2:0] fan_out_p, fan_out_n;

    int total = 0;
    int bad = 0;
    int idx = 0;
    bit halted = 1'b0;
    logic [1:0] eff [5];
    logic [1:0] pend [5];

    clkbank_top dut (
        .clk       (clk),
        .rst       (rst),
        .sync_n    (sync_n),
        .bank_cfg  (bank_cfg),
        .clk_out_p (clk_out_p),
        .clk_out_n (clk_out_n),
        .fan_out_p (fan_out_p),
        .fan_out_n (fan_out_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit exp_hi(logic [1:0] c, int i);
        case (c)
            2'b11:   return (i % 2) == 0;
            2'b01:   return ((i / 2) % 2) == 0;
            2'b10:   return ((i / 8) % 2) == 0;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s at idx %0d: actual=%0d expected=%0d", req, what, idx, act, expv);
        end
    endtask

    task automatic set_cfg(int b, logic [1:0] c);
        bank_cfg[2*b +: 2] = c;
        pend[b] = c;
    endtask

    task automatic compare(string req);
        bit e;
        for (int b = 0; b < 4; b++) begin
            e = halted ? 1'b0 : exp_hi(eff[b], idx);
            chk(clk_out_p[b] == e && clk_out_n[b] == !e, req,
                $sformatf("bank%0d p/n", b), {clk_out_p[b], clk_out_n[b]}, {e, !e});
        end
        e = halted ? 1'b0 : exp_hi(eff[4], idx);
        for (int f = 0; f < 3; f++) begin
            chk(fan_out_p[f] == e && fan_out_n[f] == !e, req,
                $sformatf("fan%0d p/n", f), {fan_out_p[f], fan_out_n[f]}, {e, !e});
        end
    endtask

    task automatic tick(string req);
        @(negedge clk);
        idx++;
        if (idx % 16 == 0)
            for (int b = 0; b < 5; b++) eff[b] = pend[b];
        compare(req);
    endtask

    task automatic wait_rise(string req);
        bit found = 1'b0;
        for (int n = 0; n < 64 && !found; n++) begin
            @(negedge clk);
            if (|clk_out_p || |fan_out_p) found = 1'b1;
        end
        chk(found, req, "restart rise seen", found, 1);
        idx = 0;
        halted = 1'b0;
        for (int b = 0; b < 5; b++) eff[b] = pend[b];
        compare(req);
    endtask

    task automatic advance_to(int m, string req);
        while (idx % 16 != m) tick(req);
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        // R8: outputs quiet during reset
        chk(clk_out_p == 4'h0 && clk_out_n == 4'hF, "R8", "single p/n in reset",
            {clk_out_p, clk_out_n}, 8'h0F);
        chk(fan_out_p == 3'h0 && fan_out_n == 3'h7, "R8", "fan p/n in reset",
            {fan_out_p, fan_out_n}, 6'h07);
        rst = 1'b0;
        for (int b = 0; b < 5; b++) begin eff[b] = 2'b00; pend[b] = 2'b00; end
        // R3: all banks disabled after reset
        repeat (20) tick("R3");
    endtask

    task automatic test_first_align();
        set_cfg(0, 2'b11);
        set_cfg(1, 2'b01);
        set_cfg(2, 2'b10);
        set_cfg(3, 2'b00);
        set_cfg(4, 2'b01);
        sync_n = 1'b0;
        repeat (40) @(negedge clk);
        // R4: halted, all low
        halted = 1'b1;
        compare("R4");
        sync_n = 1'b1;
        // R6: aligned restart
        wait_rise("R6");
        // R2 R1: divider patterns, fan pairs identical
        repeat (48) tick("R2");
    endtask

    task automatic test_short_pulse();
        advance_to(4, "R2");
        sync_n = 1'b0;
        repeat (7) tick("R5");
        sync_n = 1'b1;
        // R5: 7-cycle pulse ignored
        repeat (48) tick("R5");
    endtask

    task automatic pulse_stop(int len, string req);
        advance_to(0, req);
        sync_n = 1'b0;
        for (int k = 1; k <= 16 || k <= len; k++) begin
            if (k >= 16) halted = 1'b1;
            tick(req);
            if (k == len) sync_n = 1'b1;
        end
        sync_n = 1'b1;
        wait_rise("R6");
        repeat (32) tick("R6");
    endtask

    task automatic test_code_change();
        set_cfg(4, 2'b10);
        advance_to(5, "R7");
        set_cfg(0, 2'b01);
        set_cfg(1, 2'b00);
        set_cfg(2, 2'b11);
        // R7: old codes finish the frame, new codes from next boundary
        repeat (48) tick("R7");
    endtask

    initial begin
        test_reset();
        test_first_align();
        test_short_pulse();
        pulse_stop(40, "R4");
        pulse_stop(8, "R4");
        test_code_change();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule